// File: doc/BRIEF.md
# Threshold-Start Transmit FIFO with Underrun Discard

This block sits between a transmit DMA engine and a transmit MAC. The DMA side pushes 32-bit words, each with a tag bit, into a 128-word FIFO. A frame is closed by two tagged words in a row: its last data word and a trailing control/status word. The MAC side pulls words out over a valid/ready stream. Both streams follow the usual rules. A word moves only in a cycle where valid and ready are both high. The DMA may drop its valid at any time. The block holds the output word, tag and discard flag stable while the MAC stalls.

The unloader starts a frame in one of two ways. In threshold mode, the programmable byte threshold is below the maximum frame size of 1518 bytes, and the frame starts once the buffered byte count reaches the threshold. In store-and-forward mode, the threshold is at or above that size, and the frame starts only when a complete tagged frame is buffered. In threshold mode the FIFO can run dry in the middle of a frame. When it does, the block pulses an underrun toward the MAC, sets a sticky interrupt bit, and enters discard mode. In discard mode it keeps feeding the rest of that frame to the MAC with a discard flag set, so the MAC drops those words.

Top module: `txq_thresh_fifo`

## Requirements
- R1: `in_ready` is high exactly when fewer than DEPTH words are stored. A word is accepted when `in_valid` and `in_ready` are both high, and accepted words leave on `out_data`/`out_tag` in the order they arrived.
- R2: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high with unchanged `out_data`, `out_tag` and `out_discard`.
- R3: A frame ends at the second of two consecutive tagged words, with tag = 1 on both. In the cycle after that word is accepted, `out_valid` is low.
- R4: When the threshold is below MAX_FRAME_BYTES and the unloader is idle, the unloader starts sending in the cycle after the FIFO is non-empty and holds at least as many bytes as the threshold (4 bytes per stored word). It also starts in that cycle when a complete frame is stored.
- R5: When the threshold is at or above MAX_FRAME_BYTES, `out_valid` stays low until a complete frame (ending in a tagged pair) is stored.
- R6: If the FIFO is empty while a frame is being sent and its end has not yet been unloaded, `mac_underrun` is high for exactly that one cycle. This can happen only in threshold mode.
- R7: After an underrun, every remaining word of that frame, up to and including its closing tagged pair, is presented with `out_discard` = 1. The next frame is presented with `out_discard` = 0.
- R8: `underrun_irq` is set in the cycle after `mac_underrun` and stays set until a cycle with `irq_clear` = 1 and no new underrun. If the two coincide, the set wins.
- R9: After reset, `out_valid`, `mac_underrun` and `underrun_irq` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_thresh | input | 11 | Start threshold in bytes |
| in_valid | input | 1 | DMA word valid |
| in_ready | output | 1 | FIFO can accept a word |
| in_data | input | 32 | DMA data word |
| in_tag | input | 1 | Frame-end tag of the input word |
| out_valid | output | 1 | Word offered to the MAC |
| out_ready | input | 1 | MAC takes the word |
| out_data | output | 32 | Data word to the MAC |
| out_tag | output | 1 | Tag of the output word |
| out_discard | output | 1 | Word belongs to an underrun frame; drop it |
| mac_underrun | output | 1 | One-cycle underrun abort to the MAC |
| underrun_irq | output | 1 | Sticky underrun interrupt |
| irq_clear | input | 1 | Write-1-to-clear for the interrupt |

## Verification
The bench builds the block with DEPTH = 16 and keeps the 1518-byte frame limit. At that depth, frames of 3 to 10 words fill the FIFO and exercise back-pressure on the DMA side. The bench runs threshold values of 8 and 24 bytes, which are reachable at this depth; with a slow DMA these provoke frequent underruns and discard runs. A threshold of 100 bytes cannot be met by 16 words, so it starts frames only on complete-frame arrival, like store-and-forward. A threshold of 2047 exercises store-and-forward itself, where no underrun may occur.

// File: rtl/txq_thresh_pkg.sv
package txq_thresh_pkg;
  typedef enum logic [1:0] {
    UNL_IDLE = 2'd0,
    UNL_SEND = 2'd1,
    UNL_DROP = 2'd2
  } unl_state_t;
endpackage

// File: rtl/txq_word_store.sv
module txq_word_store #(
  parameter int DEPTH = 128,
  parameter int WW    = 33,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WW-1:0]    wr_word,
  input  logic             rd_en,
  output logic [WW-1:0]    rd_word,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [WW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      level <= level + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

  assign rd_word = mem[rp];
  assign full    = (level == CNT_W'(DEPTH));
  assign empty   = (level == '0);
endmodule

// File: rtl/txq_frame_track.sv
module txq_frame_track #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_tag,
  input  logic rd_en,
  input  logic rd_tag,
  output logic rd_end,
  output logic frame_ready
);
  logic             wr_prev, rd_prev, wr_end;
  logic [CNT_W-1:0] n_frames;

  assign wr_end = wr_en && wr_tag && wr_prev;
  assign rd_end = rd_en && rd_tag && rd_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_prev  <= 1'b0;
      rd_prev  <= 1'b0;
      n_frames <= '0;
    end else begin
      if (wr_en) wr_prev <= wr_tag && !wr_end;
      if (rd_en) rd_prev <= rd_tag && !rd_end;
      n_frames <= n_frames + CNT_W'(wr_end) - CNT_W'(rd_end);
    end
  end

  assign frame_ready = (n_frames != '0);
endmodule

// File: rtl/txq_unload_ctl.sv
module txq_unload_ctl
  import txq_thresh_pkg::*;
#(
  parameter int CNT_W           = 8,
  parameter int THR_W           = 11,
  parameter int BYTES_PER_WORD  = 4,
  parameter int MAX_FRAME_BYTES = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic             empty,
  input  logic             frame_ready,
  input  logic             rd_end,
  input  logic [THR_W-1:0] start_thresh,
  input  logic             irq_clear,
  output logic             out_valid,
  output logic             out_discard,
  output logic             mac_underrun,
  output logic             underrun_irq
);
  unl_state_t  st, st_nxt;
  logic        thr_mode, thr_met, start;
  logic [31:0] lvl_bytes;

  assign lvl_bytes = 32'(level) * 32'(BYTES_PER_WORD);
  assign thr_mode  = 32'(start_thresh) < 32'(MAX_FRAME_BYTES);
  assign thr_met   = thr_mode && (lvl_bytes >= 32'(start_thresh));
  assign start     = !empty && (frame_ready || thr_met);

  always_comb begin
    st_nxt = st;
    unique case (st)
      UNL_IDLE: if (start) st_nxt = UNL_SEND;
      UNL_SEND: begin
        if (empty)       st_nxt = UNL_DROP;
        else if (rd_end) st_nxt = UNL_IDLE;
      end
      UNL_DROP: if (rd_end) st_nxt = UNL_IDLE;
      default:  st_nxt = UNL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= UNL_IDLE;
      underrun_irq <= 1'b0;
    end else begin
      st <= st_nxt;
      if (mac_underrun)   underrun_irq <= 1'b1;
      else if (irq_clear) underrun_irq <= 1'b0;
    end
  end

  assign out_valid    = (st != UNL_IDLE) && !empty;
  assign out_discard  = (st == UNL_DROP);
  assign mac_underrun = (st == UNL_SEND) && empty;
endmodule

// File: rtl/txq_thresh_fifo.sv
module txq_thresh_fifo #(
  parameter int DATA_W          = 32,
  parameter int DEPTH           = 128,
  parameter int THR_W           = 11,
  parameter int MAX_FRAME_BYTES = 1518,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BPW   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  start_thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_tag,
  output logic              out_discard,
  output logic              mac_underrun,
  output logic              underrun_irq,
  input  logic              irq_clear
);
  logic             wr_en, rd_en, full, empty, rd_end, frame_ready;
  logic [CNT_W-1:0] level;
  logic [DATA_W:0]  rd_word;

  assign in_ready = !full;
  assign wr_en    = in_valid && in_ready;
  assign rd_en    = out_valid && out_ready;
  assign out_tag  = rd_word[DATA_W];
  assign out_data = rd_word[DATA_W-1:0];

  txq_word_store #(.DEPTH(DEPTH), .WW(DATA_W + 1)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_word({in_tag, in_data}),
    .rd_en(rd_en), .rd_word(rd_word),
    .level(level), .full(full), .empty(empty)
  );

  txq_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_tag(in_tag),
    .rd_en(rd_en), .rd_tag(out_tag),
    .rd_end(rd_end), .frame_ready(frame_ready)
  );

  txq_unload_ctl #(
    .CNT_W(CNT_W), .THR_W(THR_W), .BYTES_PER_WORD(BPW),
    .MAX_FRAME_BYTES(MAX_FRAME_BYTES)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .level(level), .empty(empty), .frame_ready(frame_ready),
    .rd_end(rd_end), .start_thresh(start_thresh), .irq_clear(irq_clear),
    .out_valid(out_valid), .out_discard(out_discard),
    .mac_underrun(mac_underrun), .underrun_irq(underrun_irq)
  );
endmodule

// File: rtl/txq_thresh_chk.sv
module txq_thresh_chk #(
  parameter int DATA_W          = 32,
  parameter int THR_W           = 11,
  parameter int MAX_FRAME_BYTES = 1518
) (
  input logic              clk,
  input logic              rst_n,
  input logic [THR_W-1:0]  start_thresh,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_tag,
  input logic              out_discard,
  input logic              mac_underrun,
  input logic              underrun_irq,
  input logic              irq_clear
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_discard)); // R2
  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_underrun |=> !mac_underrun); // R6
  AST_UNDERRUN_THR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mac_underrun |-> (32'(start_thresh) < 32'(MAX_FRAME_BYTES)) && !out_valid); // R6
  AST_DROP_AFTER_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    mac_underrun |=> out_discard); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mac_underrun |=> underrun_irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_irq && !irq_clear |=> underrun_irq); // R8
endmodule

bind txq_thresh_fifo txq_thresh_chk #(
  .DATA_W(DATA_W), .THR_W(THR_W), .MAX_FRAME_BYTES(MAX_FRAME_BYTES)
) u_chk (.*);

// File: tb/txq_thresh_fifo_tb.sv
module txq_thresh_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int MAXB       = 1518;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] start_thresh = '0;
  logic        in_valid = 1'b0, in_tag = 1'b0, out_ready = 1'b0, irq_clear = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_tag, out_discard, mac_underrun, underrun_irq;
  logic [31:0] out_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txq_thresh_fifo #(.DEPTH(DEPTH), .MAX_FRAME_BYTES(MAXB)) u_dut (.*);

  int n_tests = 0, n_fail = 0, cyc = 0, n_under = 0;
  logic [32:0] q[$];
  int  frames = 0, mst = 0;
  bit  wprev = 0, rprev = 0, irq_m = 0;
  bit  cur_v = 0;
  logic [32:0] cur_w;
  int  wleft = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic bit exp_start(int sz, int fr, int thr);
    return (sz > 0) && (fr > 0 || (thr < MAXB && sz * 4 >= thr));
  endfunction

  task automatic cycle(input int pv, input int pr, input int pc, input bit newf);
    bit e_rdy, e_val, e_und, wr, rd, endw;
    int sz;
    @(negedge clk);
    if (!cur_v && wleft == 0 && newf) wleft = 3 + int'($urandom % 8);
    if (!cur_v && wleft > 0) begin
      cur_w = {(wleft <= 2), $urandom};
      cur_v = 1;
    end
    in_valid  = cur_v && (int'($urandom % 100) < pv);
    in_tag    = cur_w[32];
    in_data   = cur_w[31:0];
    out_ready = (int'($urandom % 100) < pr);
    irq_clear = (int'($urandom % 100) < pc);
    #1;
    sz    = q.size();
    e_rdy = sz < DEPTH;
    e_val = (mst != 0) && sz > 0;
    e_und = (mst == 1) && sz == 0;
    chk(in_ready == e_rdy, "R1 in_ready", in_ready, e_rdy);
    chk(out_valid == e_val, "R3 R4 R5 out_valid", out_valid, e_val);
    chk(mac_underrun == e_und, "R6 mac_underrun", mac_underrun, e_und);
    chk(underrun_irq == irq_m, "R8 underrun_irq", underrun_irq, irq_m);
    if (e_val) begin
      chk({out_tag, out_data} == q[0], "R1 out word order", {out_tag, out_data}, q[0]);
      chk(out_discard == (mst == 2), "R7 out_discard", out_discard, mst == 2);
    end
    if (e_und) n_under++;
    wr = in_valid && e_rdy;
    rd = e_val && out_ready;
    endw = 0;
    if (rd) begin
      endw = q[0][32] && rprev;
      rprev = q[0][32] && !endw;
      void'(q.pop_front());
    end
    case (mst)
      0: if (exp_start(sz, frames, int'(start_thresh))) mst = 1;
      1: if (sz == 0) mst = 2; else if (endw) mst = 0;
      default: if (endw) mst = 0;
    endcase
    if (endw) frames--;
    if (wr) begin
      q.push_back(cur_w);
      if (cur_w[32] && wprev) begin frames++; wprev = 0; end
      else wprev = cur_w[32];
      cur_v = 0;
      wleft--;
    end
    if (e_und) irq_m = 1; else if (irq_clear) irq_m = 0;
  endtask

  task automatic phase(input int thr, input int n, input int pv, input int pr, input int pc);
    start_thresh = 11'(thr);
    for (int i = 0; i < n; i++) cycle(pv, pr, pc, 1);
    for (int i = 0; i < 300; i++) cycle(90, 100, 0, 0);
    chk(q.size() == 0 && out_valid == 0, "R3 drained idle", q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 0, "R9 reset out_valid", out_valid, 0);
    chk(in_ready == 1, "R9 reset in_ready", in_ready, 1);
    chk(mac_underrun == 0, "R9 reset mac_underrun", mac_underrun, 0);
    chk(underrun_irq == 0, "R9 reset underrun_irq", underrun_irq, 0);
    // R5 directed: partial frame in store-and-forward mode must not start
    start_thresh = 11'd2047;
    for (int i = 0; i < 20; i++) cycle(100, 100, 0, (i == 0));
    chk(n_under == 0, "R5 no underrun in store-and-forward", n_under, 0);
    phase(2047, 4000, 60, 70, 2);
    chk(n_under == 0, "R5 R6 no underrun above max threshold", n_under, 0);
    phase(8, 4000, 30, 100, 3);
    chk(n_under > 0, "R6 underruns provoked in threshold mode", n_under, 1);
    phase(24, 4000, 70, 50, 5);
    phase(100, 3000, 50, 60, 5);
    // R8 directed clear
    @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    irq_m = 0;
    #1;
    chk(underrun_irq == 0, "R8 write-1-to-clear", underrun_irq, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule